// File: doc/BRIEF.md
# Serial Transceiver Status Flags

This block keeps the status word of a serial transceiver and presents it as a 32-bit read value. Pulses from the transmit path, the receive path and the line monitor set sticky flags. These pulses are: the holding-to-shift-register transfer, the end of a transmitted frame, a break detection, and level changes on the active-low clear-to-send input. Each flag is cleared by its own software rule. The first kind of rule is a write of zero to a status bit. The second is any write to the data register. The third is a status read followed later by a data-register write.

Software drives status-read, status-write and data-write strobes together with the write data. The five receive-error flags are level inputs that are registered into the low bits of the word. A single registered interrupt output combines the four event flags, each masked by its own enable input. The clear-to-send input is asynchronous and passes through a synchronizer before its edges are detected.

Top module: `uart_stat_reg`

## Requirements
- R1: After reset the status word reads 0x000000C0: transmit-empty (bit 7) and frame-complete (bit 6) are 1, all other bits are 0, and `irq` is 0.
- R2: Bits 31 to 10 and bit 5 always read 0, and status writes with those bits set to 1 change nothing.
- R3: While `cts_watch_en` is 1, a level change on `cts_n` sets bit 9 at the third rising clock edge after the change. While `cts_watch_en` is 0, a change never sets bit 9.
- R4: A status write with bit 9 (or bit 8) equal to 0 clears that flag. Writing 1 leaves the flag as it was.
- R5: `ev_hold_xfer` sets bit 7 at the next edge. Any `wr_data` pulse clears it.
- R6: A `rd_stat` while bit 6 is 1 arms the clear. A later `wr_data` while armed clears bit 6 and disarms. A `wr_data` that is not armed leaves bit 6 set.
- R7: An `ev_frame_done` between the arming read and the data write disarms, so bit 6 stays 1 after that write.
- R8: When a set event and a clear action hit the same flag in the same cycle, the flag ends up 1.
- R9: `ev_break` sets bit 8 as a sticky flag.
- R10: Bits 4 to 0 show `rx_err[4:0]` one edge after it is sampled (idle at bit 4, then overrun, noise, framing, parity at bit 0). Status writes do not change these bits.
- R11: `irq` is 1 one edge after any flag among bits 9, 8, 7, 6 is 1 with its enable (`ie_cts`, `ie_brk`, `ie_txe`, `ie_tc`) set, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cts_n | input | 1 | Asynchronous clear-to-send line, active low |
| cts_watch_en | input | 1 | Enables change detection on cts_n |
| ie_cts | input | 1 | Interrupt enable for bit 9 |
| ie_brk | input | 1 | Interrupt enable for bit 8 |
| ie_txe | input | 1 | Interrupt enable for bit 7 |
| ie_tc | input | 1 | Interrupt enable for bit 6 |
| ev_hold_xfer | input | 1 | Pulse: holding register moved into shifter |
| ev_frame_done | input | 1 | Pulse: data frame fully shifted out |
| ev_break | input | 1 | Pulse: break detected on the line |
| rx_err | input | ERRW | Receive error levels (idle, overrun, noise, framing, parity) |
| rd_stat | input | 1 | Status register read strobe |
| wr_stat | input | 1 | Status register write strobe |
| wr_data | input | 1 | Data register write strobe |
| wdata | input | DW | Write data for status writes |
| stat_word | output | DW | Current status word |
| irq | output | 1 | Registered combined interrupt |

## Verification
The bench builds the block with its defaults: a 32-bit word, five error bits and a two-stage synchronizer. With these defaults the full word, including the upper zero bits, can be compared exactly. The three-edge latency of the clear-to-send path is also a fixed, checkable count. The vector walk covers the arming and disarming of the frame-complete clear, same-cycle set and clear collisions, and status writes of all ones. These cases depend only on the strobe order, not on the parameters.

// File: rtl/uart_stat_pkg.sv
package uart_stat_pkg;
  localparam int BIT_CTS = 9;
  localparam int BIT_BRK = 8;
  localparam int BIT_TXE = 7;
  localparam int BIT_TC  = 6;
  localparam int NFLAG   = 3;   // sticky flags built from one cell: cts, brk, txe
  localparam logic [31:0] STAT_RST = 32'h0000_00C0;
endpackage

// File: rtl/stat_sync_edge.sv
module stat_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic edge_o
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      prev  <= chain[STAGES-1];
    end
  end

  assign edge_o = chain[STAGES-1] ^ prev;
endmodule

// File: rtl/stat_sticky_flag.sv
module stat_sticky_flag #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= RST_VAL;
    else if (set_i) q <= 1'b1;
    else if (clr_i) q <= 1'b0;
  end

  // set has priority over a same-cycle clear
  p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
    set_i |=> q);
  p_rise_needs_set_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(q) |-> $past(set_i));
  p_fall_needs_clr_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(q) |-> ($past(clr_i) && !$past(set_i)));
endmodule

// File: rtl/stat_tc_seq.sv
module stat_tc_seq (
  input  logic clk,
  input  logic rst,
  input  logic done_i,
  input  logic rd_i,
  input  logic wr_i,
  output logic tc_q
);
  logic armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      tc_q  <= 1'b1;
      armed <= 1'b0;
    end else begin
      if (done_i)             tc_q <= 1'b1;
      else if (wr_i && armed) tc_q <= 1'b0;

      if (done_i || wr_i)     armed <= 1'b0;
      else if (rd_i && tc_q)  armed <= 1'b1;
    end
  end

  p_tc_clear_seq_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(tc_q) |-> ($past(wr_i) && $past(armed)));
  p_tc_done_r7: assert property (@(posedge clk) disable iff (rst)
    done_i |=> (tc_q && !armed));
endmodule

// File: rtl/uart_stat_reg.sv
module uart_stat_reg
  import uart_stat_pkg::*;
#(
  parameter int DW          = 32,
  parameter int ERRW        = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cts_n,
  input  logic            cts_watch_en,
  input  logic            ie_cts,
  input  logic            ie_brk,
  input  logic            ie_txe,
  input  logic            ie_tc,
  input  logic            ev_hold_xfer,
  input  logic            ev_frame_done,
  input  logic            ev_break,
  input  logic [ERRW-1:0] rx_err,
  input  logic            rd_stat,
  input  logic            wr_stat,
  input  logic            wr_data,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   stat_word,
  output logic            irq
);
  localparam int UPW = DW - (BIT_CTS + 1);

  logic              cts_edge;
  logic [ERRW-1:0]   err_q;
  logic [NFLAG-1:0]  f_set, f_clr, f_q;
  logic              tc_q;
  logic [3:0]        irq_src;
  logic              unused_wbits;

  assign unused_wbits = ^wdata;

  stat_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(cts_n), .edge_o(cts_edge)
  );

  // index 0: cts change, 1: break, 2: transmit empty
  assign f_set[0] = cts_edge && cts_watch_en;
  assign f_clr[0] = wr_stat && !wdata[BIT_CTS];
  assign f_set[1] = ev_break;
  assign f_clr[1] = wr_stat && !wdata[BIT_BRK];
  assign f_set[2] = ev_hold_xfer;
  assign f_clr[2] = wr_data;

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    stat_sticky_flag #(.RST_VAL(i == 2)) u_flag (
      .clk(clk), .rst(rst), .set_i(f_set[i]), .clr_i(f_clr[i]), .q(f_q[i])
    );
  end

  stat_tc_seq u_tc (
    .clk(clk), .rst(rst), .done_i(ev_frame_done),
    .rd_i(rd_stat), .wr_i(wr_data), .tc_q(tc_q)
  );

  always_ff @(posedge clk) begin
    if (rst) err_q <= '0;
    else     err_q <= rx_err;
  end

  assign irq_src = {f_q[0] & ie_cts, f_q[1] & ie_brk, f_q[2] & ie_txe, tc_q & ie_tc};

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |irq_src;
  end

  assign stat_word = {{UPW{1'b0}}, f_q[0], f_q[1], f_q[2], tc_q,
                      {(BIT_TC - ERRW){1'b0}}, err_q};

  p_irq_src_r11: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(|(stat_word[BIT_CTS:BIT_TC] & {ie_cts, ie_brk, ie_txe, ie_tc})));
  p_cts_gate_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_word[BIT_CTS]) |-> $past(cts_watch_en));
  p_err_mirror_r10: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (stat_word[ERRW-1:0] == $past(rx_err)));
endmodule

// File: tb/tb_uart_stat_reg.sv
module tb_uart_stat_reg;
  typedef struct packed {
    logic xf, dn, bk, rd, ws, wd;
    logic [9:0] wv;
    logic [4:0] rx;
    logic [9:0] ex;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 10'h000, 5'h00, 10'h040}, // R6 unarmed write keeps tc, R5 clear txe
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 10'h000, 5'h00, 10'h040}, // R6 arm
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 10'h000, 5'h00, 10'h000}, // R6 clear
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 10'h000, 5'h00, 10'h080}, // R5 set
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 10'h000, 5'h00, 10'h0C0}, // R6 set
    '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 10'h000, 5'h15, 10'h1D5}, // R9 R10
    '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 10'h3FF, 5'h15, 10'h1D5}, // R4 R2 write ones
    '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 10'h000, 5'h0A, 10'h0CA}, // R4 clear brk, R10
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 10'h000, 5'h00, 10'h0C0}, // R6 arm
    '{1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 10'h000, 5'h00, 10'h0C0}, // R7 disarm
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 10'h000, 5'h00, 10'h040}, // R7 tc kept
    '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0, 10'h000, 5'h00, 10'h140}, // R9 R6
    '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0, 10'h000, 5'h00, 10'h140}, // R8 brk
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1, 10'h000, 5'h00, 10'h180}, // R8 txe, R6
    '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 10'h000, 5'h00, 10'h080}  // R4
  };

  logic clk = 1'b0, rst = 1'b1;
  logic cts_n = 1'b1, cts_watch_en = 1'b0;
  logic ie_cts = 1'b0, ie_brk = 1'b0, ie_txe = 1'b0, ie_tc = 1'b0;
  logic ev_hold_xfer = 1'b0, ev_frame_done = 1'b0, ev_break = 1'b0;
  logic [4:0] rx_err = '0;
  logic rd_stat = 1'b0, wr_stat = 1'b0, wr_data = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] stat_word;
  logic irq;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  uart_stat_reg dut (
    .clk(clk), .rst(rst), .cts_n(cts_n), .cts_watch_en(cts_watch_en),
    .ie_cts(ie_cts), .ie_brk(ie_brk), .ie_txe(ie_txe), .ie_tc(ie_tc),
    .ev_hold_xfer(ev_hold_xfer), .ev_frame_done(ev_frame_done), .ev_break(ev_break),
    .rx_err(rx_err), .rd_stat(rd_stat), .wr_stat(wr_stat), .wr_data(wr_data),
    .wdata(wdata), .stat_word(stat_word), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic idle_inputs();
    ev_hold_xfer = 0; ev_frame_done = 0; ev_break = 0;
    rd_stat = 0; wr_stat = 0; wr_data = 0; wdata = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset word", stat_word, 32'h0000_00C0);
    chk("R1 reset irq", {31'b0, irq}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      ev_hold_xfer = VEC[i].xf; ev_frame_done = VEC[i].dn; ev_break = VEC[i].bk;
      rd_stat = VEC[i].rd; wr_stat = VEC[i].ws; wr_data = VEC[i].wd;
      wdata = {22'h3FFFFF, VEC[i].wv};
      rx_err = VEC[i].rx;
      @(negedge clk);
      chk($sformatf("R2/R4-R10 vector %0d", i), stat_word, {22'b0, VEC[i].ex});
      idle_inputs();
    end
    // state now 0x080

    // R3: change ignored while watch disabled
    cts_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R3 disabled no flag", stat_word, 32'h080);
    cts_watch_en = 1'b1; ie_cts = 1'b1;
    cts_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R3 not yet after two edges", stat_word, 32'h080);
    @(negedge clk);
    chk("R3 flag on third edge", stat_word, 32'h280);
    chk("R11 irq lags flag", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R11 irq raised", {31'b0, irq}, 32'h1);
    wr_stat = 1'b1; wdata = 32'h0000_0000;
    @(negedge clk);
    idle_inputs();
    chk("R4 cts cleared", stat_word, 32'h080);
    @(negedge clk);
    chk("R11 irq drops", {31'b0, irq}, 32'h0);
    ie_cts = 1'b0; ie_txe = 1'b1;
    @(negedge clk);
    chk("R11 txe enable", {31'b0, irq}, 32'h1);
    ie_txe = 1'b0; ie_tc = 1'b1;
    @(negedge clk);
    chk("R11 tc clear masks", {31'b0, irq}, 32'h0);

    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 reset again", stat_word, 32'h0000_00C0);
    @(negedge clk);
    chk("R11 tc enabled after reset", {31'b0, irq}, 32'h1);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule